// File: doc/BRIEF.md
# Block-Ack Reorder Window Tracker

This block follows one receive block-ack session over a sequence space that wraps at 4096. It holds the window start, a flag saying whether that start is valid, and a presence bitmap. Bit k of the bitmap means the frame at window start + k is being held for reordering. For every frame strobe, the block measures the frame's distance from the window start. It classifies the frame as a duplicate, a late frame, a 2K jump, the window head, a frame that leaves a gap, or a frame beyond the window end. It then emits an opcode and the number of frames released, slides the window, and raises one event pulse.

Software sets up a session with a single strobe. The strobe loads the start (valid or not), the window size and the duplicate-check mode, and zeroes the bitmap. A 2K jump sets a sticky error flag. While that flag is set, every frame is passed straight through without touching the window. A separate strobe clears the flag. Frame storage and aging timers belong to the surrounding queue logic.

Top module: `reo_window_tracker`

## Requirements
- R1: The offset of a frame is (frm_seq − window start) modulo 4096. Every classification and every start update wraps modulo 4096.
- R2: cfg_win_m1 holds the window entry count N minus one. A value of 0 gives a single-entry session, in which any frame other than the head lies beyond the window. The largest value uses every bitmap entry.
- R3: When start_vld is low, an accepted frame loads its own sequence number as the window start and sets start_vld. A sw_setup strobe loads win_start from sw_ssn and start_vld from sw_ssn_vld.
- R4: A non-duplicate frame with offset 1..N−1 holds its bitmap entry. It gives opcode 2 (queue), fwd_cnt 0 and an ev_hole pulse.
- R5: A frame at offset 0 gives opcode 1 (forward head). fwd_cnt is 1 plus the number of contiguous held entries that follow it. The start advances by fwd_cnt, and the vacated entries are cleared in the same cycle.
- R6: A frame is a duplicate if its entry is already held, or if it equals the last released number (start − 1) after a release. A duplicate gives opcode 3, fwd_cnt 0 and an ev_dup pulse, and leaves the state unchanged.
- R7: With cfg_dup_off high, no duplicate check is made. The frame is classified by its offset only.
- R8: A non-duplicate frame with offset 4096−LATE_N..4095 gives opcode 4 (late drop), an ev_late pulse and fwd_cnt 0. It leaves the window unchanged.
- R9: A frame with offset 2048..4095−LATE_N gives opcode 6, fwd_cnt 1 and an ev_jump pulse, and sets err_flag. The window is left unchanged.
- R10: While err_flag is set, a frame gives opcode 7 (bypass), fwd_cnt 1 and no event, and the window state does not change. sw_err_clr clears the flag, and a frame in that same cycle is processed as if the flag were clear.
- R11: A frame with offset N..2047 gives opcode 5 (flush). fwd_cnt is the number of held entries plus 1, the bitmap is cleared, and the start becomes frm_seq + 1.
- R12: Outputs are registered and appear one cycle after the strobe, with at most one event pulse. Without a frame, op_vld stays low and the opcode is 0. sw_setup takes priority over a frame in the same cycle, and that frame is ignored. After reset, start_vld, err_flag, win_start and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | Frame strobe |
| frm_seq | input | SEQ_W (12) | Frame sequence number |
| cfg_win_m1 | input | MAP_AW (8) | Window entry count minus one |
| cfg_dup_off | input | 1 | Disable duplicate detection |
| sw_setup | input | 1 | Session setup strobe |
| sw_ssn_vld | input | 1 | Start-valid value loaded on setup |
| sw_ssn | input | SEQ_W (12) | Start value loaded on setup |
| sw_err_clr | input | 1 | Clear the sticky jump error |
| op_vld | output | 1 | Opcode valid |
| op_code | output | 3 | Reorder opcode |
| fwd_cnt | output | CNT_W (9) | Frames released this event |
| ev_dup | output | 1 | Duplicate pulse |
| ev_late | output | 1 | Late frame pulse |
| ev_hole | output | 1 | Gap pulse |
| ev_jump | output | 1 | 2K jump pulse |
| err_flag | output | 1 | Sticky jump error |
| win_start | output | SEQ_W (12) | Current window start |
| start_vld | output | 1 | Window start is valid |

## Verification
The bench builds the tracker with a 32-entry bitmap and a 64-number late range. With these values a full window, a release of the whole window and a flush of every held entry take only a few dozen frames. Because the late range is larger than the bitmap, the late boundary is tested separately from the window edge. The sequence space stays at 12 bits, so wrap-around, the 2047/2048 step and the late/jump boundary are all exercised at their real positions.

// File: rtl/reo_pkg.sv
package reo_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_FWD_HEAD  = 3'd1,
    OP_QUEUE     = 3'd2,
    OP_DROP_DUP  = 3'd3,
    OP_DROP_LATE = 3'd4,
    OP_FLUSH     = 3'd5,
    OP_JUMP      = 3'd6,
    OP_BYPASS    = 3'd7
  } reo_op_e;

  typedef enum logic [2:0] {
    CL_DUP, CL_LATE, CL_JUMP, CL_HEAD, CL_GAP, CL_AHEAD
  } reo_cls_e;
endpackage

// File: rtl/reo_rst_sync.sv
module reo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/reo_classify.sv
module reo_classify
  import reo_pkg::*;
#(
  parameter int SEQ_W  = 12,
  parameter int MAP_N  = 256,
  parameter int LATE_N = 256,
  localparam int MAP_AW = $clog2(MAP_N)
) (
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [SEQ_W-1:0]  base_i,
  input  logic [MAP_AW-1:0] win_m1_i,
  input  logic [MAP_N-1:0]  bitmap_i,
  input  logic              dup_off_i,
  input  logic              last_vld_i,
  output reo_cls_e          cls_o,
  output logic [SEQ_W-1:0]  off_o
);
  localparam logic [SEQ_W-1:0] LATE_LO = SEQ_W'((1 << SEQ_W) - LATE_N);
  localparam logic [SEQ_W-1:0] HALF    = SEQ_W'(1 << (SEQ_W - 1));

  logic [MAP_AW:0]    win_n;
  logic               in_win, held, is_last;
  logic [SEQ_W-1:0]   prev_seq;

  always_comb begin
    off_o    = seq_i - base_i;
    win_n    = {1'b0, win_m1_i} + (MAP_AW+1)'(1);
    in_win   = off_o < SEQ_W'(win_n);
    held     = in_win && bitmap_i[off_o[MAP_AW-1:0]];
    prev_seq = base_i - SEQ_W'(1);
    is_last  = last_vld_i && (seq_i == prev_seq);
    if (!dup_off_i && (held || is_last)) cls_o = CL_DUP;
    else if (off_o >= LATE_LO)           cls_o = CL_LATE;
    else if (off_o >= HALF)              cls_o = CL_JUMP;
    else if (off_o == '0)                cls_o = CL_HEAD;
    else if (in_win)                     cls_o = CL_GAP;
    else                                 cls_o = CL_AHEAD;
  end
endmodule

// File: rtl/reo_runlen.sv
module reo_runlen #(
  parameter int MAP_N = 256,
  localparam int CNT_W = $clog2(MAP_N) + 1
) (
  input  logic [MAP_N-1:0] bitmap_i,
  output logic [CNT_W-1:0] run_o,
  output logic [CNT_W-1:0] pop_o
);
  logic go;

  always_comb begin
    run_o = '0;
    pop_o = '0;
    go    = 1'b1;
    for (int i = 1; i < MAP_N; i++) begin
      if (go && bitmap_i[i]) run_o = run_o + CNT_W'(1);
      else                   go    = 1'b0;
      pop_o = pop_o + CNT_W'(bitmap_i[i]);
    end
  end
endmodule

// File: rtl/reo_window_tracker.sv
module reo_window_tracker
  import reo_pkg::*;
#(
  parameter int SEQ_W  = 12,
  parameter int MAP_N  = 256,
  parameter int LATE_N = 256,
  localparam int MAP_AW = $clog2(MAP_N),
  localparam int CNT_W  = MAP_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_vld,
  input  logic [SEQ_W-1:0]  frm_seq,
  input  logic [MAP_AW-1:0] cfg_win_m1,
  input  logic              cfg_dup_off,
  input  logic              sw_setup,
  input  logic              sw_ssn_vld,
  input  logic [SEQ_W-1:0]  sw_ssn,
  input  logic              sw_err_clr,
  output logic              op_vld,
  output logic [2:0]        op_code,
  output logic [CNT_W-1:0]  fwd_cnt,
  output logic              ev_dup,
  output logic              ev_late,
  output logic              ev_hole,
  output logic              ev_jump,
  output logic              err_flag,
  output logic [SEQ_W-1:0]  win_start,
  output logic              start_vld
);
  logic rst_ni;

  logic [SEQ_W-1:0] start_q, start_d;
  logic             sv_q, sv_d;
  logic [MAP_N-1:0] bmp_q, bmp_d;
  logic             lastv_q, lastv_d;
  logic             err_q, err_d, err_eff;
  reo_op_e          op_q, op_d;
  logic             opv_q, opv_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       ev_q, ev_d;
  logic             st_en;

  logic [SEQ_W-1:0] base, off;
  reo_cls_e         cls;
  logic [CNT_W-1:0] run, pop, adv;

  reo_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  assign base = sv_q ? start_q : frm_seq;

  reo_classify #(.SEQ_W(SEQ_W), .MAP_N(MAP_N), .LATE_N(LATE_N)) u_cls (
    .seq_i(frm_seq), .base_i(base), .win_m1_i(cfg_win_m1), .bitmap_i(bmp_q),
    .dup_off_i(cfg_dup_off), .last_vld_i(lastv_q), .cls_o(cls), .off_o(off)
  );

  reo_runlen #(.MAP_N(MAP_N)) u_run (.bitmap_i(bmp_q), .run_o(run), .pop_o(pop));

  assign adv = run + CNT_W'(1);

  // next-state
  always_comb begin
    start_d = start_q;
    sv_d    = sv_q;
    bmp_d   = bmp_q;
    lastv_d = lastv_q;
    err_eff = err_q & ~sw_err_clr;
    err_d   = err_eff;
    op_d    = OP_NONE;
    cnt_d   = '0;
    ev_d    = 4'b0000;            // {jump, hole, late, dup}
    opv_d   = frm_vld & ~sw_setup;
    if (sw_setup) begin
      start_d = sw_ssn;
      sv_d    = sw_ssn_vld;
      bmp_d   = '0;
      lastv_d = 1'b0;
    end else if (frm_vld) begin
      if (err_eff) begin
        op_d  = OP_BYPASS;
        cnt_d = CNT_W'(1);
      end else begin
        sv_d    = 1'b1;
        start_d = base;
        unique case (cls)
          CL_DUP: begin
            op_d = OP_DROP_DUP;
            ev_d = 4'b0001;
          end
          CL_LATE: begin
            op_d = OP_DROP_LATE;
            ev_d = 4'b0010;
          end
          CL_JUMP: begin
            op_d  = OP_JUMP;
            cnt_d = CNT_W'(1);
            err_d = 1'b1;
            ev_d  = 4'b1000;
          end
          CL_HEAD: begin
            op_d    = OP_FWD_HEAD;
            cnt_d   = adv;
            start_d = base + SEQ_W'(adv);
            bmp_d   = bmp_q >> adv;
            lastv_d = 1'b1;
          end
          CL_GAP: begin
            op_d = OP_QUEUE;
            bmp_d[off[MAP_AW-1:0]] = 1'b1;
            ev_d = 4'b0100;
          end
          default: begin
            op_d    = OP_FLUSH;
            cnt_d   = pop + CNT_W'(1);
            bmp_d   = '0;
            start_d = frm_seq + SEQ_W'(1);
            lastv_d = 1'b1;
          end
        endcase
      end
    end
  end

  assign st_en = sw_setup | frm_vld | sw_err_clr;

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      sv_q    <= 1'b0;
      bmp_q   <= '0;
      lastv_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (st_en) begin
      start_q <= start_d;
      sv_q    <= sv_d;
      bmp_q   <= bmp_d;
      lastv_q <= lastv_d;
      err_q   <= err_d;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_NONE;
      opv_q <= 1'b0;
      cnt_q <= '0;
      ev_q  <= 4'b0000;
    end else begin
      op_q  <= op_d;
      opv_q <= opv_d;
      cnt_q <= cnt_d;
      ev_q  <= ev_d;
    end
  end

  assign op_vld    = opv_q;
  assign op_code   = op_q;
  assign fwd_cnt   = cnt_q;
  assign ev_dup    = ev_q[0];
  assign ev_late   = ev_q[1];
  assign ev_hole   = ev_q[2];
  assign ev_jump   = ev_q[3];
  assign err_flag  = err_q;
  assign win_start = start_q;
  assign start_vld = sv_q;

  assert_head_clear_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    bmp_q[0] == 1'b0);

  assert_single_event_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ev_jump, ev_hole, ev_late, ev_dup}));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q && !sw_err_clr |=> err_q);

  assert_bypass_when_err_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    frm_vld && err_q && !sw_err_clr && !sw_setup |=> op_code == 3'd7 && fwd_cnt == CNT_W'(1));

  assert_head_slide_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    frm_vld && !sw_setup && !err_eff && cls == CL_HEAD |=> win_start == $past(base) + SEQ_W'(fwd_cnt));

  assert_dup_keeps_map_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    op_vld && op_code == 3'd3 |-> $stable(bmp_q) && $stable(start_q));

  assert_idle_no_op_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !frm_vld |=> !op_vld && op_code == 3'd0);
endmodule

// File: tb/sim_reo_window_tracker.sv
module sim_reo_window_tracker;
  localparam int SEQ_W  = 12;
  localparam int MAP_N  = 32;
  localparam int LATE_N = 64;
  localparam int MAP_AW = $clog2(MAP_N);
  localparam int CNT_W  = MAP_AW + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic frm_vld, cfg_dup_off, sw_setup, sw_ssn_vld, sw_err_clr;
  logic [SEQ_W-1:0] frm_seq, sw_ssn;
  logic [MAP_AW-1:0] cfg_win_m1;
  logic op_vld, ev_dup, ev_late, ev_hole, ev_jump, err_flag, start_vld;
  logic [2:0] op_code;
  logic [CNT_W-1:0] fwd_cnt;
  logic [SEQ_W-1:0] win_start;

  always #2 clk = ~clk;   // 250 MHz

  reo_window_tracker #(.SEQ_W(SEQ_W), .MAP_N(MAP_N), .LATE_N(LATE_N)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_seq(frm_seq),
    .cfg_win_m1(cfg_win_m1), .cfg_dup_off(cfg_dup_off), .sw_setup(sw_setup),
    .sw_ssn_vld(sw_ssn_vld), .sw_ssn(sw_ssn), .sw_err_clr(sw_err_clr),
    .op_vld(op_vld), .op_code(op_code), .fwd_cnt(fwd_cnt), .ev_dup(ev_dup),
    .ev_late(ev_late), .ev_hole(ev_hole), .ev_jump(ev_jump), .err_flag(err_flag),
    .win_start(win_start), .start_vld(start_vld)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_start; bit m_sv, m_err, m_lastv;
  bit m_held [0:4095];
  int x_op, x_cnt; bit x_vld; bit [3:0] x_ev;

  function automatic void model(bit vld, int seq, bit setup, bit ssnv, int ssn,
                                bit eclr, int n, bit dupoff);
    int s, off, k; bit eff;
    x_vld = vld && !setup; x_op = 0; x_cnt = 0; x_ev = 0;
    eff = m_err && !eclr;
    m_err = eff;
    if (setup) begin
      m_start = ssn; m_sv = ssnv; m_lastv = 0; m_held = '{default: 0};
    end else if (vld) begin
      if (eff) begin
        x_op = 7; x_cnt = 1;
      end else begin
        s = m_sv ? m_start : seq;
        m_sv = 1; m_start = s;
        off = (seq - s) & 4095;
        if (!dupoff && ((off < n && m_held[seq]) || (m_lastv && seq == ((s + 4095) & 4095)))) begin
          x_op = 3; x_ev = 4'b0001;
        end else if (off >= 4096 - LATE_N) begin
          x_op = 4; x_ev = 4'b0010;
        end else if (off >= 2048) begin
          x_op = 6; x_cnt = 1; x_ev = 4'b1000; m_err = 1;
        end else if (off == 0) begin
          k = 1;
          while (k < n && m_held[(s + k) & 4095]) k++;
          for (int j = 0; j < k; j++) m_held[(s + j) & 4095] = 0;
          x_op = 1; x_cnt = k; m_start = (s + k) & 4095; m_lastv = 1;
        end else if (off < n) begin
          m_held[seq] = 1; x_op = 2; x_ev = 4'b0100;
        end else begin
          k = 0;
          for (int j = 0; j < n; j++) k += m_held[(s + j) & 4095];
          m_held = '{default: 0};
          x_op = 5; x_cnt = k + 1; m_start = (seq + 1) & 4095; m_lastv = 1;
        end
      end
    end
  endfunction

  task automatic compare(string tag);
    bit bad = 0;
    checks++;
    if (op_vld !== x_vld) begin bad = 1; $display("FAIL %s op_vld got %0b exp %0b", tag, op_vld, x_vld); end
    if (op_code !== 3'(x_op)) begin bad = 1; $display("FAIL %s op_code got %0d exp %0d", tag, op_code, x_op); end
    if (fwd_cnt !== CNT_W'(x_cnt)) begin bad = 1; $display("FAIL %s fwd_cnt got %0d exp %0d", tag, fwd_cnt, x_cnt); end
    if ({ev_jump, ev_hole, ev_late, ev_dup} !== x_ev) begin bad = 1;
      $display("FAIL %s events got %b exp %b", tag, {ev_jump, ev_hole, ev_late, ev_dup}, x_ev); end
    if (err_flag !== m_err) begin bad = 1; $display("FAIL %s err_flag got %0b exp %0b", tag, err_flag, m_err); end
    if (start_vld !== m_sv) begin bad = 1; $display("FAIL %s start_vld got %0b exp %0b", tag, start_vld, m_sv); end
    if (win_start !== SEQ_W'(m_start)) begin bad = 1; $display("FAIL %s win_start got %0d exp %0d", tag, win_start, m_start); end
    if (bad) errors++;
  endtask

  // one cycle: drive just after an edge, compare just after the next edge
  task automatic step(bit vld, int seq, string tag, bit setup = 0, bit ssnv = 0,
                      int ssn = 0, bit eclr = 0);
    frm_vld = vld; frm_seq = SEQ_W'(seq); sw_setup = setup; sw_ssn_vld = ssnv;
    sw_ssn = SEQ_W'(ssn); sw_err_clr = eclr;
    model(vld, seq, setup, ssnv, ssn, eclr, int'(cfg_win_m1) + 1, cfg_dup_off);
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic setup(int ssn, int m1, string tag);
    cfg_win_m1 = MAP_AW'(m1);
    step(0, 0, tag, 1, 1, ssn);
  endtask

  initial begin
    rst_n = 0; frm_vld = 0; frm_seq = 0; cfg_win_m1 = 0; cfg_dup_off = 0;
    sw_setup = 0; sw_ssn_vld = 0; sw_ssn = 0; sw_err_clr = 0;
    m_start = 0; m_sv = 0; m_err = 0; m_lastv = 0; m_held = '{default: 0};
    x_vld = 0; x_op = 0; x_cnt = 0; x_ev = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1 compare("R12 reset");
    cfg_win_m1 = MAP_AW'(7);
    step(1, 4090, "R3 first frame");
    step(0, 0, "R12 idle");
    setup(4094, 7, "R3 setup");
    step(1, 4095, "R4 gap");
    step(1, 0, "R1 wrap gap");
    step(1, 4095, "R6 dup held");
    step(1, 4094, "R5 head release");
    step(1, 4093, "R8 late");
    step(1, 0, "R6 dup last");
    cfg_dup_off = 1;
    step(1, 0, "R7 no dup");
    step(1, 3, "R7 gap");
    step(1, 3, "R7 gap again");
    cfg_dup_off = 0;
    step(1, 3, "R6 dup");
    step(1, 21, "R11 flush");
    setup(100, 0, "R2 single");
    step(1, 100, "R2 head");
    step(1, 105, "R2 beyond");
    step(1, 106, "R2 head again");
    setup(200, MAP_N - 1, "R2 wide");
    step(1, 231, "R2 last entry");
    step(1, 232, "R2 past edge");
    step(1, 233 + 2047, "R11 offset 2047");
    step(1, (2281 + 4032 - 1) % 4096, "R9 jump edge");
    step(1, 5, "R10 bypass");
    step(1, 2281, "R10 bypass head");
    step(1, 2281, "R10 clear", 0, 0, 0, 1);
    step(1, (2282 + 4032) % 4096, "R8 late edge");
    step(1, 2282 + 2048, "R9 jump");
    step(0, 0, "R10 sticky hold");
    step(0, 0, "R10 clear idle", 0, 0, 0, 1);
    step(1, 77, "R12 setup wins", 1, 0, 50);
    step(1, 900, "R3 load after setup");
    for (int i = 0; i < 400; i++) begin
      int r, sq;
      r = $urandom_range(0, 99);
      if (r < 3) setup($urandom_range(0, 4095), $urandom_range(0, MAP_N - 1), "R2 rnd setup");
      else begin
        cfg_dup_off = ($urandom_range(0, 9) == 0);
        if (r < 70) sq = m_start + $urandom_range(0, MAP_N + 4);
        else if (r < 90) sq = m_start - $urandom_range(1, LATE_N + 8);
        else sq = $urandom_range(0, 4095);
        step($urandom_range(0, 5) != 0, sq & 4095, "R1 mix", 0, 0, 0, r > 96);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12 watchdog expired got hang exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule